// File: doc/BRIEF.md
# Two-Phase Bus Clock Generator with Slow-Access Stretch

This block derives the two non-overlapping processor clocks, phase one and phase two, from a fast master clock. A normal bus cycle lasts `DIV` master-clock periods. When the address decoder flags an access to the slow peripheral bus, that one bus cycle is doubled to `2*DIV` master periods. The extra time goes to phase two, which gives slow peripheral devices a longer transfer window.

The block also controls the bidirectional buffer that joins the processor data bus to the peripheral data bus. The buffer enable opens only during a slow access, inside the phase-two window, and closes one master period before phase two falls. The direction output follows the read/write line. Both the slow select and read/write are captured once per bus cycle, on the master edge at which phase one rises. A change that arrives later in the cycle waits for the next cycle.

The outputs are clocks and control levels with no data path, so no valid/ready handshake applies at the edge of the block. All outputs come straight from flops on the master clock.

Top module: `clk_stretcher`

## Requirements
- R1: While reset is asserted and in the first master cycle after it, ph1 is 1, ph2 is 0, buf_en is 0 and buf_dir_read is 0. The first bus cycle runs at the normal length.
- R2: Let H = DIV/2-1, and number the master cycles of a bus cycle from 0. A normal bus cycle lasts DIV master cycles. ph1 is high in cycles 0..H-1, and ph2 is high in cycles H+1..DIV-2.
- R3: A stretched bus cycle lasts 2*DIV master cycles. ph1 is high in cycles 0..H-1, and ph2 is high in cycles H+1..2*DIV-2. Phase two, counted together with its trailing gap, therefore spans 3*DIV/2 master cycles, which is one and a half normal bus cycles.
- R4: ph1 and ph2 are never high together. Every transition between them has at least one master cycle with both low.
- R5: sel_slow and rw_read are sampled only on the master edge that starts a bus cycle (where ph1 rises). A value present at any other edge has no effect on the current cycle.
- R6: buf_en is 1 only in a stretched cycle, in cycles H+1..2*DIV-3. It is therefore high only while ph2 is high, and it is low in the last ph2 cycle.
- R7: buf_dir_read equals the rw_read value sampled at the start of the current bus cycle, with 1 meaning a read (peripheral bus drives the processor bus). It holds steady for the whole cycle.
- R8: DIV is an even number of at least 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, DIV times the normal bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_slow | input | 1 | Decoded slow peripheral access; stretches the next bus cycle |
| rw_read | input | 1 | Processor read/write: 1 read, 0 write |
| ph1 | output | 1 | Phase-one processor clock |
| ph2 | output | 1 | Phase-two processor clock |
| buf_en | output | 1 | Enable for the bus bridge buffer |
| buf_dir_read | output | 1 | Buffer direction, 1 = peripheral to processor |

## Verification
The assertions check on every master cycle the rules that hold regardless of stimulus. The two phases never overlap, and each transition has a gap where both are low. The buffer enable is high only under phase two and is gone before phase two falls. The direction output stays steady within a bus cycle, and the cycle counter never passes the end of the current cycle length.

Some behaviour only the bench's scenarios can show. These are the exact edge positions for normal and stretched cycles, that a select which changes in mid-cycle is ignored until the next phase-one rise, back-to-back stretched cycles, and the reset state. The bench shows them by comparing every output with a reference model built from the requirements, under random select and read/write changes on every master cycle.

// File: rtl/clkstr_pkg.sv
package clkstr_pkg;
  // Width of the bus-cycle position counter for a given normal length.
  function automatic int cnt_width(input int div);
    return $clog2(2 * div);
  endfunction
endpackage

// File: rtl/clkstr_seq.sv
module clkstr_seq #(
  parameter int DIV = 8,
  localparam int CW = clkstr_pkg::cnt_width(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_slow,
  input  logic          rw_read,
  output logic [CW-1:0] pos_nxt,
  output logic          str_nxt,
  output logic          rd_nxt
);
  localparam int NLAST = DIV - 1;
  localparam int SLAST = 2 * DIV - 1;

  logic [CW-1:0] pos_q;
  logic          str_q;
  logic          rd_q;
  logic          wrap;

  assign wrap = str_q ? (pos_q == CW'(SLAST)) : (pos_q == CW'(NLAST));

  always_comb begin
    pos_nxt = wrap ? '0 : pos_q + 1'b1;
    str_nxt = wrap ? sel_slow : str_q;
    rd_nxt  = wrap ? rw_read : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      str_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      str_q <= str_nxt;
      rd_q  <= rd_nxt;
    end
  end

  // R2 / R3: position never passes the end of the current cycle length
  assert_pos_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    str_q ? (pos_q <= CW'(SLAST)) : (pos_q <= CW'(NLAST)));
  // R5: sampled select holds for the whole cycle
  assert_sel_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0) |-> $stable(str_q));
endmodule

// File: rtl/clkstr_phase.sv
module clkstr_phase #(
  parameter int DIV = 8,
  localparam int CW = clkstr_pkg::cnt_width(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pos_nxt,
  input  logic          str_nxt,
  output logic          ph1,
  output logic          ph2
);
  localparam int H = DIV / 2 - 1;
  localparam int NP2_END = DIV - 2;
  localparam int SP2_END = 2 * DIV - 2;

  logic p1_d, p2_d;

  always_comb begin
    p1_d = (pos_nxt < CW'(H));
    p2_d = (pos_nxt >= CW'(H + 1)) &&
           (pos_nxt <= (str_nxt ? CW'(SP2_END) : CW'(NP2_END)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1 <= 1'b1;
      ph2 <= 1'b0;
    end else begin
      ph1 <= p1_d;
      ph2 <= p2_d;
    end
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1 && ph2));
  assert_gap_after_p1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph1) |-> !ph2);
  assert_gap_after_p2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph2) |-> !ph1);
endmodule

// File: rtl/clkstr_buf.sv
module clkstr_buf #(
  parameter int DIV = 8,
  localparam int CW = clkstr_pkg::cnt_width(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pos_nxt,
  input  logic          str_nxt,
  input  logic          rd_nxt,
  output logic          buf_en,
  output logic          buf_dir_read
);
  localparam int EN_FIRST = DIV / 2;
  localparam int EN_LAST  = 2 * DIV - 3;

  logic en_d;
  assign en_d = str_nxt && (pos_nxt >= CW'(EN_FIRST)) && (pos_nxt <= CW'(EN_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en       <= 1'b0;
      buf_dir_read <= 1'b0;
    end else begin
      buf_en       <= en_d;
      buf_dir_read <= rd_nxt;
    end
  end
endmodule

// File: rtl/clk_stretcher.sv
module clk_stretcher #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_slow,
  input  logic rw_read,
  output logic ph1,
  output logic ph2,
  output logic buf_en,
  output logic buf_dir_read
);
  localparam int CW = clkstr_pkg::cnt_width(DIV);

  logic [CW-1:0] pos_nxt;
  logic          str_nxt;
  logic          rd_nxt;

  initial begin
    assert_div_ok_R8: assert ((DIV % 2 == 0) && (DIV >= 4))
      else $error("DIV must be even and at least 4");
  end

  clkstr_seq #(.DIV(DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_slow(sel_slow), .rw_read(rw_read),
    .pos_nxt(pos_nxt), .str_nxt(str_nxt), .rd_nxt(rd_nxt)
  );

  clkstr_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .pos_nxt(pos_nxt), .str_nxt(str_nxt),
    .ph1(ph1), .ph2(ph2)
  );

  clkstr_buf #(.DIV(DIV)) u_buf (
    .clk(clk), .rst_n(rst_n), .pos_nxt(pos_nxt), .str_nxt(str_nxt),
    .rd_nxt(rd_nxt), .buf_en(buf_en), .buf_dir_read(buf_dir_read)
  );

  // R6: enable only under phase two, and dropped before phase two falls
  assert_en_under_p2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> ph2);
  assert_en_early_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph2) |-> !$past(buf_en));
  // R7: direction only moves at a phase-one rise
  assert_dir_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ph1) |-> $stable(buf_dir_read));
endmodule

// File: tb/clk_stretcher_test.sv
module clk_stretcher_test;
  localparam int DIV = 8;
  localparam int H = DIV / 2 - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_slow = 1'b0;
  logic rw_read = 1'b0;
  logic ph1, ph2, buf_en, buf_dir_read;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_stretcher #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .sel_slow(sel_slow), .rw_read(rw_read),
    .ph1(ph1), .ph2(ph2), .buf_en(buf_en), .buf_dir_read(buf_dir_read)
  );

  // Reference position model built from the requirements
  int  m_pos = 0;
  bit  m_str = 1'b0;
  bit  m_rd  = 1'b0;
  bit  prev_p1 = 1'b1, prev_p2 = 1'b0;

  function automatic int cyc_len(input bit s);
    return s ? 2 * DIV : DIV;
  endfunction
  function automatic bit exp_p1(input int p);
    return p < H;
  endfunction
  function automatic bit exp_p2(input int p, input bit s);
    return (p >= H + 1) && (p <= cyc_len(s) - 2);
  endfunction
  function automatic bit exp_en(input int p, input bit s);
    return s && (p >= H + 1) && (p <= 2 * DIV - 3);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_pos == cyc_len(m_str) - 1) begin
        m_pos <= 0;
        m_str <= sel_slow;
        m_rd  <= rw_read;
      end else begin
        m_pos <= m_pos + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pos %0d stretch %0b: actual %0b expected %0b",
               req, what, m_pos, m_str, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "ph1", ph1, exp_p1(m_pos));
    chk(m_str ? "R3" : "R2", "ph2", ph2, exp_p2(m_pos, m_str));
    chk("R6", "buf_en", buf_en, exp_en(m_pos, m_str));
    chk("R7", "buf_dir_read", buf_dir_read, m_rd);
    chk("R4", "no overlap", ph1 & ph2, 1'b0);
    if (ph1 && !prev_p1) chk("R4", "gap before ph1", prev_p2, 1'b0);
    if (ph2 && !prev_p2) chk("R4", "gap before ph2", prev_p1, 1'b0);
    prev_p1 = ph1;
    prev_p2 = ph2;
  endtask

  // one master cycle: check at negedge, then drive next inputs
  task automatic step(input bit s, input bit r);
    @(negedge clk);
    check_all();
    sel_slow = s;
    rw_read  = r;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ph1 in reset", ph1, 1'b1);
    chk("R1", "ph2 in reset", ph2, 1'b0);
    chk("R1", "buf_en in reset", buf_en, 1'b0);
    chk("R1", "dir in reset", buf_dir_read, 1'b0);
    rst_n = 1'b1;
    // R1: first cycle normal even with select held high after release
    sel_slow = 1'b1;
    rw_read = 1'b1;
    for (int i = 0; i < DIV - 1; i++) step(1'b1, 1'b1);
    // directed: back-to-back stretched cycles, read
    for (int i = 0; i < 4 * DIV; i++) step(1'b1, 1'b1);
    // directed: normal cycles, write
    for (int i = 0; i < 3 * DIV; i++) step(1'b0, 1'b0);
    // R5: select pulsing in mid-cycle only, never at a cycle start
    for (int i = 0; i < 4 * DIV; i++) begin
      bit late;
      late = (m_pos != DIV - 1) && (m_pos != 2 * DIV - 1);
      step(late, late);
    end
    // random select and direction changes every master cycle
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, $urandom % 2);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule